// File: doc/BRIEF.md
# Programmable Counter/Timer Channel

This block is one counter/timer channel with four operating modes. In event mode it counts time-base ticks, raises an interrupt when the count reaches a programmed match value, and wraps to zero when the count overflows. In pulse mode it emits a one-cycle output pulse and an interrupt once every N ticks. In delay mode a rising edge on the gate input arms a count of N ticks, after which the output goes high. In PWM mode the output alternates between a high phase and a low phase, and each phase length is programmed separately in ticks.

A tick comes from one of two sources. The internal source is a divided system clock, with one tick every `BASE_DIV` clocks. The external source is a clock pin that is synchronized into the system clock domain; either its rising edges or its falling edges can be selected as ticks. Each interrupt appears as a one-cycle pulse and also sets a sticky flag, which software clears with a clear strobe.

Top module: `ctr_timer_chan`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `count`, `cnt_out`, `irq_pulse` and `irq_sticky` are all 0.
- R2: Mode encoding is 0 = event, 1 = pulse, 2 = delay, 3 = PWM. In event mode `count` goes up by one on each tick and holds when there is no tick. With `src_ext` = 0, a tick occurs every `BASE_DIV` system clocks (default: every clock).
- R3: When `count` is at its maximum value, the next tick in event mode sets it to 0, and counting continues from there.
- R4: In event mode with `match_en` = 1, `irq_pulse` is high for exactly the one cycle in which `count` first shows `match_val`. Counting carries on after the match.
- R5: With `src_ext` = 1, ticks are rising edges of `ext_clk` when `edge_fall` = 0 and falling edges when `edge_fall` = 1. A level change on the pin updates `count` on the third rising edge of `clk` after it.
- R6: In pulse mode, `cnt_out` and `irq_pulse` are high together for one cycle once every N ticks, where N is `period_n`. A value of N below 2 behaves as 2.
- R7: In delay mode, a rising edge on `gate` clears `count`, drives `cnt_out` low and starts a delay. `cnt_out` goes high, together with an `irq_pulse`, N ticks later and stays high until the next gate rise. A value of N below 1 behaves as 1.
- R8: In PWM mode, `cnt_out` is high for `high_cnt` ticks and then low for `low_cnt` ticks, starting with the high phase. A value below 2 in either field behaves as 2. PWM mode raises no interrupt.
- R9: New `high_cnt` and `low_cnt` values take effect only on the tick that ends a low phase. A phase already in progress keeps its old length.
- R10: In the cycle after `mode` changes, `count` is 0 and `cnt_out` is low. No tick is counted on that edge.
- R11: `irq_sticky` goes high with every `irq_pulse` and is cleared by `irq_clr`. If a new interrupt and `irq_clr` land on the same edge, the interrupt wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_ext | input | 1 | 1 = use external clock ticks, 0 = use internal time base |
| ext_clk | input | 1 | External clock pin (asynchronous) |
| edge_fall | input | 1 | 1 = count falling external edges, 0 = count rising edges |
| gate | input | 1 | Gate pin that starts a delay (asynchronous) |
| mode | input | 2 | Operating mode (see R2) |
| match_en | input | 1 | Enables the match interrupt in event mode |
| match_val | input | WIDTH | Match value |
| period_n | input | WIDTH | Pulse divisor or delay count |
| high_cnt | input | WIDTH | PWM high-phase length in ticks |
| low_cnt | input | WIDTH | PWM low-phase length in ticks |
| irq_clr | input | 1 | Clears the sticky interrupt flag |
| cnt_out | output | 1 | Counter output pin |
| count | output | WIDTH | Current count |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| irq_sticky | output | 1 | Sticky interrupt flag |

## Verification
A new interrupt and a software clear strobe can hit the same clock edge. The bench sets pulse mode with a divisor of 4 and raises `irq_clr` just before the edge that carries the first pulse. It checks that the sticky flag is still set after that edge, and that it drops on the following edge once no new interrupt arrives. A PWM reprogram can also land in the middle of a high phase. The bench judges it by the exact per-cycle output pattern: the old phase lengths must run out before the new ones appear.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    typedef enum logic [1:0] {
        MODE_EVENT = 2'd0,
        MODE_PULSE = 2'd1,
        MODE_DELAY = 2'd2,
        MODE_PWM   = 2'd3
    } ctr_mode_e;

    typedef struct packed {
        logic out;
        logic irq;
        logic sticky;
        logic phase_hi;
        logic running;
    } ctr_flags_t;

    localparam int unsigned PWM_MIN   = 2;
    localparam int unsigned PULSE_MIN = 2;
    localparam int unsigned DELAY_MIN = 1;

endpackage

// File: rtl/ctr_sync_edge.sv
module ctr_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic sel_fall,
    output logic hit
);
    localparam int unsigned DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sh_q;
    logic             rise;
    logic             fall;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[DEPTH-2:0], din};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
    assign hit  = sel_fall ? fall : rise;

    // R5: a selected edge produces a single-cycle hit
    p_edge_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        (rise || fall) |=> !(rise || fall));

endmodule

// File: rtl/ctr_core.sv
module ctr_core
    import ctr_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             gate_rise,
    input  ctr_mode_e        mode,
    input  logic             match_en,
    input  logic [WIDTH-1:0] match_val,
    input  logic [WIDTH-1:0] period_n,
    input  logic [WIDTH-1:0] high_cnt,
    input  logic [WIDTH-1:0] low_cnt,
    input  logic             irq_clr,
    output logic [WIDTH-1:0] count,
    output logic             cnt_out,
    output logic             irq_pulse,
    output logic             irq_sticky
);
    localparam logic [WIDTH-1:0] LIM_PWM   = WIDTH'(PWM_MIN);
    localparam logic [WIDTH-1:0] LIM_PULSE = WIDTH'(PULSE_MIN);
    localparam logic [WIDTH-1:0] LIM_DELAY = WIDTH'(DELAY_MIN);

    function automatic logic [WIDTH-1:0] floor_at(input logic [WIDTH-1:0] v,
                                                  input logic [WIDTH-1:0] lim);
        return (v < lim) ? lim : v;
    endfunction

    ctr_mode_e        mode_q;
    logic [WIDTH-1:0] cnt_q, cnt_d, cnt_inc;
    logic [WIDTH-1:0] hi_q, hi_d, lo_q, lo_d;
    ctr_flags_t       fl_q, fl_d;
    logic [WIDTH-1:0] pulse_n, delay_n;

    assign cnt_inc = cnt_q + WIDTH'(1);
    assign pulse_n = floor_at(period_n, LIM_PULSE);
    assign delay_n = floor_at(period_n, LIM_DELAY);

    always_comb begin
        cnt_d      = cnt_q;
        hi_d       = hi_q;
        lo_d       = lo_q;
        fl_d       = fl_q;
        fl_d.irq   = 1'b0;
        if (mode != mode_q) begin
            cnt_d         = '0;
            fl_d.out      = 1'b0;
            fl_d.phase_hi = 1'b1;
            fl_d.running  = 1'b0;
            hi_d          = floor_at(high_cnt, LIM_PWM);
            lo_d          = floor_at(low_cnt, LIM_PWM);
        end else begin
            unique case (mode)
                MODE_EVENT: begin
                    fl_d.out = 1'b0;
                    if (tick) begin
                        cnt_d = cnt_inc;
                        if (match_en && cnt_inc == match_val) fl_d.irq = 1'b1;
                    end
                end
                MODE_PULSE: begin
                    fl_d.out = 1'b0;
                    if (tick) begin
                        if (cnt_inc >= pulse_n) begin
                            cnt_d    = '0;
                            fl_d.out = 1'b1;
                            fl_d.irq = 1'b1;
                        end else begin
                            cnt_d = cnt_inc;
                        end
                    end
                end
                MODE_DELAY: begin
                    if (gate_rise) begin
                        cnt_d        = '0;
                        fl_d.out     = 1'b0;
                        fl_d.running = 1'b1;
                    end else if (fl_q.running && tick) begin
                        cnt_d = cnt_inc;
                        if (cnt_inc >= delay_n) begin
                            fl_d.out     = 1'b1;
                            fl_d.irq     = 1'b1;
                            fl_d.running = 1'b0;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        fl_d.out = fl_q.phase_hi;
                        if (fl_q.phase_hi) begin
                            if (cnt_inc >= hi_q) begin
                                fl_d.phase_hi = 1'b0;
                                cnt_d         = '0;
                            end else begin
                                cnt_d = cnt_inc;
                            end
                        end else begin
                            if (cnt_inc >= lo_q) begin
                                fl_d.phase_hi = 1'b1;
                                cnt_d         = '0;
                                hi_d          = floor_at(high_cnt, LIM_PWM);
                                lo_d          = floor_at(low_cnt, LIM_PWM);
                            end else begin
                                cnt_d = cnt_inc;
                            end
                        end
                    end
                end
            endcase
        end
        fl_d.sticky = fl_d.irq | (fl_q.sticky & ~irq_clr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= mode;
            cnt_q  <= '0;
            hi_q   <= LIM_PWM;
            lo_q   <= LIM_PWM;
            fl_q   <= '{out: 1'b0, irq: 1'b0, sticky: 1'b0, phase_hi: 1'b1, running: 1'b0};
        end else begin
            mode_q <= mode;
            cnt_q  <= cnt_d;
            hi_q   <= hi_d;
            lo_q   <= lo_d;
            fl_q   <= fl_d;
        end
    end

    assign count      = cnt_q;
    assign cnt_out    = fl_q.out;
    assign irq_pulse  = fl_q.irq;
    assign irq_sticky = fl_q.sticky;

    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_EVENT && mode_q == MODE_EVENT && !tick) |=> $stable(cnt_q));

    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_EVENT && mode_q == MODE_EVENT && tick && cnt_q == '1) |=> cnt_q == '0);

    p_irq_single_r4: assert property (@(posedge clk) disable iff (rst)
        fl_q.irq |=> !fl_q.irq);

    p_mode_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (mode != mode_q) |=> (cnt_q == '0 && !fl_q.out));

    p_sticky_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (fl_q.sticky && !irq_clr) |=> fl_q.sticky);

endmodule

// File: rtl/ctr_timer_chan.sv
module ctr_timer_chan
    import ctr_pkg::*;
#(
    parameter int unsigned WIDTH       = 32,
    parameter int unsigned BASE_DIV    = 1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_ext,
    input  logic             ext_clk,
    input  logic             edge_fall,
    input  logic             gate,
    input  logic [1:0]       mode,
    input  logic             match_en,
    input  logic [WIDTH-1:0] match_val,
    input  logic [WIDTH-1:0] period_n,
    input  logic [WIDTH-1:0] high_cnt,
    input  logic [WIDTH-1:0] low_cnt,
    input  logic             irq_clr,
    output logic             cnt_out,
    output logic [WIDTH-1:0] count,
    output logic             irq_pulse,
    output logic             irq_sticky
);
    logic ext_hit;
    logic gate_rise;
    logic base_tick;
    logic tick;

    ctr_sync_edge #(.STAGES(SYNC_STAGES)) i_ext_sync (
        .clk(clk), .rst(rst), .din(ext_clk), .sel_fall(edge_fall), .hit(ext_hit)
    );

    ctr_sync_edge #(.STAGES(SYNC_STAGES)) i_gate_sync (
        .clk(clk), .rst(rst), .din(gate), .sel_fall(1'b0), .hit(gate_rise)
    );

    generate
        if (BASE_DIV <= 1) begin : g_base_every
            assign base_tick = 1'b1;
        end else begin : g_base_div
            localparam int unsigned DW = $clog2(BASE_DIV);
            localparam logic [DW-1:0] LAST = DW'(BASE_DIV - 1);
            logic [DW-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst)               div_q <= '0;
                else if (div_q == LAST) div_q <= '0;
                else                   div_q <= div_q + DW'(1);
            end
            assign base_tick = (div_q == LAST);
        end
    endgenerate

    assign tick = src_ext ? ext_hit : base_tick;

    ctr_core #(.WIDTH(WIDTH)) i_core (
        .clk(clk), .rst(rst), .tick(tick), .gate_rise(gate_rise),
        .mode(ctr_mode_e'(mode)), .match_en(match_en), .match_val(match_val),
        .period_n(period_n), .high_cnt(high_cnt), .low_cnt(low_cnt),
        .irq_clr(irq_clr), .count(count), .cnt_out(cnt_out),
        .irq_pulse(irq_pulse), .irq_sticky(irq_sticky)
    );

endmodule

// File: tb/test_ctr_timer_chan.sv
module test_ctr_timer_chan;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        src_ext = 1'b0, ext_clk = 1'b0, edge_fall = 1'b0, gate = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        match_en = 1'b0, irq_clr = 1'b0;
    logic [31:0] match_val = '0, period_n = '0, high_cnt = '0, low_cnt = '0;
    logic        cnt_out, irq_pulse, irq_sticky;
    logic [31:0] count;
    logic        n_out, n_irq, n_sticky;
    logic [7:0]  n_count;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctr_timer_chan i_ctr_timer_chan (
        .clk(clk), .rst(rst), .src_ext(src_ext), .ext_clk(ext_clk), .edge_fall(edge_fall),
        .gate(gate), .mode(mode), .match_en(match_en), .match_val(match_val),
        .period_n(period_n), .high_cnt(high_cnt), .low_cnt(low_cnt), .irq_clr(irq_clr),
        .cnt_out(cnt_out), .count(count), .irq_pulse(irq_pulse), .irq_sticky(irq_sticky)
    );

    ctr_timer_chan #(.WIDTH(8)) i_ctr_timer_chan_narrow (
        .clk(clk), .rst(rst), .src_ext(src_ext), .ext_clk(ext_clk), .edge_fall(edge_fall),
        .gate(gate), .mode(mode), .match_en(1'b0), .match_val(match_val[7:0]),
        .period_n(period_n[7:0]), .high_cnt(high_cnt[7:0]), .low_cnt(low_cnt[7:0]),
        .irq_clr(irq_clr), .cnt_out(n_out), .count(n_count), .irq_pulse(n_irq),
        .irq_sticky(n_sticky)
    );

    localparam int TBL_N   [8] = '{0, 1, 2, 3, 4, 5, 7, 10};
    localparam int TBL_EXP [8] = '{20, 20, 20, 13, 10, 8, 5, 4};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    function automatic logic pwm_boundary_exp(input int k);
        if (k <= 4)  return 1'b1;
        if (k <= 6)  return 1'b0;
        if (k <= 11) return 1'b1;
        if (k <= 15) return 1'b0;
        return 1'b1;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int pulses;
        int match_cnt;
        logic [31:0] cnt_at_irq;

        // R1 reset state
        step(3);
        check("R1 count", count, 0);
        check("R1 out", cnt_out, 0);
        check("R1 irq", irq_pulse, 0);
        check("R1 sticky", irq_sticky, 0);
        rst = 1'b0;

        // R6 table: pulse period with clamp
        for (int i = 0; i < 8; i++) begin
            mode = 2'd0; step(2);
            mode = 2'd1; period_n = TBL_N[i];
            pulses = 0;
            for (int k = 0; k < 41; k++) begin
                step(1);
                if (irq_pulse && cnt_out) pulses++;
            end
            check($sformatf("R6 pulses N=%0d", TBL_N[i]), pulses, TBL_EXP[i]);
        end

        // R2 event counting on internal base
        mode = 2'd3; step(1);
        mode = 2'd0; step(11);
        check("R2 event count", count, 10);

        // R10 mode change clears count and output
        mode = 2'd1; step(1);
        check("R10 count cleared", count, 0);
        check("R10 out low", cnt_out, 0);

        // R4 match interrupt, counting continues
        irq_clr = 1'b1; period_n = 32'd4; step(1);
        irq_clr = 1'b0;
        mode = 2'd0; match_en = 1'b1; match_val = 32'd5;
        match_cnt = 0; cnt_at_irq = '1;
        for (int k = 0; k < 12; k++) begin
            step(1);
            if (irq_pulse) begin
                match_cnt++;
                cnt_at_irq = count;
            end
        end
        check("R4 single match irq", match_cnt, 1);
        check("R4 count at irq", cnt_at_irq, 5);
        check("R4 count continues", count, 11);
        check("R11 sticky set", irq_sticky, 1);
        irq_clr = 1'b1; step(1);
        irq_clr = 1'b0;
        check("R11 sticky cleared", irq_sticky, 0);
        match_en = 1'b0;

        // R11 set wins over clear on the same edge
        mode = 2'd1; period_n = 32'd4; step(4);
        irq_clr = 1'b1; step(1);
        check("R11 coincident irq", irq_pulse, 1);
        check("R11 set wins", irq_sticky, 1);
        step(1);
        check("R11 clear next", irq_sticky, 0);
        irq_clr = 1'b0;

        // R3 wrap on narrow instance, R2 wide count
        mode = 2'd3; step(1);
        mode = 2'd0; step(260);
        check("R3 wrap narrow", n_count, 3);
        check("R2 wide count", count, 259);

        // R5 external rising edges
        src_ext = 1'b1; edge_fall = 1'b0;
        mode = 2'd3; step(1);
        mode = 2'd0; step(1);
        for (int c = 0; c < 5; c++) begin
            ext_clk = 1'b1; step(4);
            ext_clk = 1'b0; step(4);
        end
        step(3);
        check("R5 rising count", count, 5);
        step(6);
        check("R5 idle hold", count, 5);
        ext_clk = 1'b1; step(2);
        check("R5 latency before", count, 5);
        step(1);
        check("R5 latency third edge", count, 6);

        // R5 external falling edges
        edge_fall = 1'b1;
        mode = 2'd3; step(1);
        mode = 2'd0; step(1);
        for (int c = 0; c < 4; c++) begin
            ext_clk = 1'b0; step(4);
            ext_clk = 1'b1; step(4);
        end
        step(3);
        check("R5 falling count", count, 4);
        src_ext = 1'b0; edge_fall = 1'b0;

        // R7 delay pulse from gate
        mode = 2'd2; period_n = 32'd5; gate = 1'b0; step(1);
        gate = 1'b1; step(7);
        check("R7 still low", cnt_out, 0);
        step(1);
        check("R7 out high", cnt_out, 1);
        check("R7 irq", irq_pulse, 1);
        step(1);
        check("R7 out stays", cnt_out, 1);
        gate = 1'b0; step(3);
        gate = 1'b1; step(3);
        check("R7 restart low", cnt_out, 0);
        check("R7 restart count", count, 0);
        gate = 1'b0;

        // R8 PWM pattern 3 high / 2 low
        high_cnt = 32'd3; low_cnt = 32'd2;
        mode = 2'd0; step(1);
        mode = 2'd3; step(1);
        check("R10 pwm entry low", cnt_out, 0);
        for (int k = 2; k < 22; k++) begin
            step(1);
            check($sformatf("R8 pwm k=%0d", k), cnt_out, ((k - 2) % 5) < 3);
        end

        // R8 clamp of small values to 2
        high_cnt = 32'd0; low_cnt = 32'd1;
        mode = 2'd0; step(1);
        mode = 2'd3; step(1);
        for (int k = 2; k < 18; k++) begin
            step(1);
            check($sformatf("R8 clamp k=%0d", k), cnt_out, ((k - 2) % 4) < 2);
        end

        // R9 new values only at period boundary
        high_cnt = 32'd3; low_cnt = 32'd2;
        mode = 2'd0; step(1);
        mode = 2'd3; step(3);
        high_cnt = 32'd5; low_cnt = 32'd4;
        for (int k = 4; k < 17; k++) begin
            step(1);
            check($sformatf("R9 boundary k=%0d", k), cnt_out, pwm_boundary_exp(k));
        end
        check("R8 no pwm irq", irq_pulse, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule